// File: doc/BRIEF.md
# Split Base-and-Bound Address Relocator

This block turns logical addresses into physical addresses for two independent streams: instruction fetches driven from the program counter, and data accesses driven from the memory address register. Each stream owns a base register and a bound register. The physical address is the stream's base added to the logical address. The bound holds the segment length, so an access is legal only when its logical address is strictly below the bound.

The four registers change only through a single configuration write port, and only while the supervisor input is high. A write attempted without supervisor rights leaves every register as it was and raises a one-cycle privilege error. Each request path works out its result in the same cycle and registers it, so the result appears one cycle after the request together with a valid flag. A faulting access returns a physical address of zero and raises fault. It has no other effect.

Top module: `bb_relocator`

## Requirements
- R1: After reset the fetch and data response valid flags, faults and physical addresses are 0, and all four registers are 0.
- R2: A fetch request in cycle N produces fetch_vld_o=1 in cycle N+1. Its physical address is program base + logical address, truncated to ADDR_W bits, when the address is legal.
- R3: A data request in cycle N produces data_vld_o=1 in cycle N+1. Its physical address is data base + logical address, truncated, when the address is legal.
- R4: An access is legal only when its logical address is strictly less than its stream's bound. An address equal to or above the bound sets the fault output and returns a physical address of 0.
- R5: The fetch path uses only the program pair and the data path uses only the data pair. Writing one pair never changes the results of the other stream.
- R6: A write with cfg_we_i=1 and sup_i=1 loads cfg_wdata_i into the register that cfg_sel_i selects: 0 = program base, 1 = program bound, 2 = data base, 3 = data bound. The new value applies to requests in the following cycle.
- R7: A write with cfg_we_i=1 and sup_i=0 leaves every register unchanged and drives priv_err_o high for exactly one cycle.
- R8: Cycles with no request drive the matching valid flag, fault and physical address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sup_i | input | 1 | Supervisor mode |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | ADDR_W | Register write data |
| priv_err_o | output | 1 | Write attempted outside supervisor mode |
| fetch_req_i | input | 1 | Fetch request |
| fetch_la_i | input | ADDR_W | Program-counter logical address |
| fetch_vld_o | output | 1 | Fetch result valid |
| fetch_pa_o | output | ADDR_W | Fetch physical address |
| fetch_fault_o | output | 1 | Fetch bound violation |
| data_req_i | input | 1 | Data request |
| data_la_i | input | ADDR_W | Memory-address-register logical address |
| data_vld_o | output | 1 | Data result valid |
| data_pa_o | output | ADDR_W | Data physical address |
| data_fault_o | output | 1 | Data bound violation |

## Verification
The assertions check several properties on every cycle. The valid flag follows its request by exactly one cycle. A faulting or idle response carries a zero address. A privilege error is always a one-cycle pulse. A denied write leaves the registers stable. The bench's scenarios are needed for the arithmetic: correct base addition with wraparound, the strict less-than decision at bound-1, bound and bound+1, a bound of zero, and isolation between the two register pairs. The bench checks these against its own model.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    SEL_PBASE  = 2'd0,
    SEL_PBOUND = 2'd1,
    SEL_DBASE  = 2'd2,
    SEL_DBOUND = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/bb_regs.sv
module bb_regs import bb_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic              priv_err_o,
  output logic [ADDR_W-1:0] pbase_o,
  output logic [ADDR_W-1:0] pbound_o,
  output logic [ADDR_W-1:0] dbase_o,
  output logic [ADDR_W-1:0] dbound_o
);
  logic [ADDR_W-1:0] regs_q [4];
  logic              wr_ok;

  assign wr_ok = we_i && sup_i;

  for (genvar g = 0; g < 4; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (wr_ok && sel_i == 2'(g))        regs_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) priv_err_o <= 1'b0;
    else         priv_err_o <= we_i && !sup_i;
  end

  assign pbase_o  = regs_q[SEL_PBASE];
  assign pbound_o = regs_q[SEL_PBOUND];
  assign dbase_o  = regs_q[SEL_DBASE];
  assign dbound_o = regs_q[SEL_DBOUND];

  AST_DENIED_WRITE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sup_i) |=> ($stable(pbase_o) && $stable(pbound_o) && $stable(dbase_o) && $stable(dbound_o))) else $error("denied write changed a register"); // R7
  AST_PRIV_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_err_o |-> $past(we_i && !sup_i)) else $error("spurious priv_err"); // R7
endmodule

// File: rtl/bb_path.sv
module bb_path #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] bound_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] la_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic              fault_o
);
  logic              legal;
  logic [ADDR_W-1:0] pa_d;

  assign legal = la_i < bound_i;
  assign pa_d  = base_i + la_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      pa_o    <= '0;
      fault_o <= 1'b0;
    end else begin
      vld_o   <= req_i;
      fault_o <= req_i && !legal;
      pa_o    <= (req_i && legal) ? pa_d : '0;
    end
  end

  AST_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o) else $error("valid missing"); // R2
  AST_FAULT_ZERO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (pa_o == '0)) else $error("fault with nonzero pa"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (!fault_o && pa_o == '0)) else $error("idle output active"); // R8
endmodule

// File: rtl/bb_relocator.sv
module bb_relocator #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              priv_err_o,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_la_i,
  output logic              fetch_vld_o,
  output logic [ADDR_W-1:0] fetch_pa_o,
  output logic              fetch_fault_o,
  input  logic              data_req_i,
  input  logic [ADDR_W-1:0] data_la_i,
  output logic              data_vld_o,
  output logic [ADDR_W-1:0] data_pa_o,
  output logic              data_fault_o
);
  logic [ADDR_W-1:0] pbase, pbound, dbase, dbound;

  bb_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .sup_i,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .priv_err_o,
    .pbase_o(pbase), .pbound_o(pbound), .dbase_o(dbase), .dbound_o(dbound)
  );

  bb_path #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i, .rst_ni, .base_i(pbase), .bound_i(pbound),
    .req_i(fetch_req_i), .la_i(fetch_la_i),
    .vld_o(fetch_vld_o), .pa_o(fetch_pa_o), .fault_o(fetch_fault_o)
  );

  bb_path #(.ADDR_W(ADDR_W)) u_data (
    .clk_i, .rst_ni, .base_i(dbase), .bound_i(dbound),
    .req_i(data_req_i), .la_i(data_la_i),
    .vld_o(data_vld_o), .pa_o(data_pa_o), .fault_o(data_fault_o)
  );

  AST_DATA_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_i |=> data_vld_o) else $error("data valid missing"); // R3
endmodule

// File: tb/tb_bb_relocator.sv
module tb_bb_relocator;
  localparam int ADDR_W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic sup, we;
  logic [1:0] sel;
  logic [ADDR_W-1:0] wdata, fla, dla;
  logic freq, dreq, perr, fvld, ffault, dvld, dfault;
  logic [ADDR_W-1:0] fpa, dpa;

  int checks = 0, errors = 0;
  logic [ADDR_W-1:0] m_reg [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  bb_relocator #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sup_i(sup), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .priv_err_o(perr),
    .fetch_req_i(freq), .fetch_la_i(fla), .fetch_vld_o(fvld), .fetch_pa_o(fpa), .fetch_fault_o(ffault),
    .data_req_i(dreq), .data_la_i(dla), .data_vld_o(dvld), .data_pa_o(dpa), .data_fault_o(dfault)
  );

  function automatic logic [ADDR_W-1:0] exp_pa(logic [ADDR_W-1:0] b, logic [ADDR_W-1:0] bd, logic [ADDR_W-1:0] la);
    return (la < bd) ? b + la : '0;
  endfunction

  task automatic chk(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    we = 0; freq = 0; dreq = 0;
  endtask

  // drive at negedge, sample after next posedge (at following negedge)
  task automatic wr(logic s, logic [1:0] r, logic [ADDR_W-1:0] v);
    @(negedge clk); sup = s; we = 1; sel = r; wdata = v;
    if (s) m_reg[r] = v;
    @(negedge clk); we = 0;
  endtask

  task automatic access(logic [ADDR_W-1:0] fa, logic [ADDR_W-1:0] da, string tag);
    @(negedge clk); freq = 1; dreq = 1; fla = fa; dla = da;
    @(negedge clk); freq = 0; dreq = 0;
    chk({tag, " R2 fetch vld"}, ADDR_W'(fvld), 1);
    chk({tag, " R2 fetch pa"}, fpa, exp_pa(m_reg[0], m_reg[1], fa));
    chk({tag, " R4 fetch fault"}, ADDR_W'(ffault), ADDR_W'(!(fa < m_reg[1])));
    chk({tag, " R3 data vld"}, ADDR_W'(dvld), 1);
    chk({tag, " R3 data pa"}, dpa, exp_pa(m_reg[2], m_reg[3], da));
    chk({tag, " R4 data fault"}, ADDR_W'(dfault), ADDR_W'(!(da < m_reg[3])));
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    sup = 0; sel = 0; wdata = 0; fla = 0; dla = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fvld", ADDR_W'(fvld), 0); chk("R1 dvld", ADDR_W'(dvld), 0);
    chk("R1 fpa", fpa, 0); chk("R1 dpa", dpa, 0);
    chk("R1 perr", ADDR_W'(perr), 0);
    access(32'h0, 32'h0, "R1 zero bounds"); // all registers 0 -> faults

    // R6 supervisor writes
    wr(1, 2'd0, 32'h1000_0000); wr(1, 2'd1, 32'h100);
    wr(1, 2'd2, 32'h2000_0000); wr(1, 2'd3, 32'h40);
    access(32'h10, 32'h10, "R6 basic");
    // R4 boundaries
    access(32'hFF, 32'h3F, "R4 bound-1");
    access(32'h100, 32'h40, "R4 at bound");
    access(32'h101, 32'h41, "R4 bound+1");
    // R2 wraparound
    wr(1, 2'd0, 32'hFFFF_FFF0);
    access(32'h20, 32'h0, "R2 wrap");

    // R7 denied write
    @(negedge clk); sup = 0; we = 1; sel = 2'd1; wdata = 32'h0;
    @(negedge clk); we = 0;
    chk("R7 priv_err pulse", ADDR_W'(perr), 1);
    @(negedge clk);
    chk("R7 priv_err one cycle", ADDR_W'(perr), 0);
    access(32'h20, 32'h10, "R7 bound unchanged");

    // R5 isolation: write data pair, fetch unchanged
    wr(1, 2'd2, 32'h0000_5000); wr(1, 2'd3, 32'h1_0000);
    access(32'h80, 32'h8000, "R5 isolation");
    wr(1, 2'd1, 32'h8);
    access(32'h80, 32'h8000, "R5 fetch only");

    // R8 idle
    @(negedge clk);
    chk("R8 fvld idle", ADDR_W'(fvld), 0); chk("R8 fpa idle", fpa, 0);
    chk("R8 dvld idle", ADDR_W'(dvld), 0); chk("R8 dfault idle", ADDR_W'(dfault), 0);

    // random
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(3) == 0)
        wr(1'($urandom_range(3) != 0), 2'($urandom_range(3)),
           ($urandom_range(1) != 0) ? $urandom() : ADDR_W'($urandom_range(4096)));
      access(ADDR_W'($urandom_range(8192)), ($urandom_range(7) == 0) ? $urandom() : ADDR_W'($urandom_range(8192)), "R2 R3 R4 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule